// File: doc/BRIEF.md
# Set/Clear Port Control Register

This block holds the control and status word of one storage port. Software never writes the word as a whole. A write to the set address turns on every bit written as 1. A write to the clear address turns off every bit written as 1. Zero bits in either write leave the word unchanged. The read port always shows the current status. This is the configuration bits, the self-clearing action bits and a read-only port-ready flag, which is bit 31.

Three action bits are sequenced by a small state machine. The states are ST_HELD (port held in reset), ST_IDLE (reset released, port not yet initialised), ST_INIT (initialisation running) and ST_READY (port ready). The transitions are:

- HELD_TO_IDLE on a clear write of bit 0.
- IDLE_TO_INIT and READY_TO_INIT on a set write of bit 2.
- INIT_TO_READY when the initialisation timer expires.
- ANY_TO_HELD on a set write of bit 0, from IDLE, INIT or READY.

A separate device-reset flag stays on until the link-up input reports a live link.

The bit positions are fixed because software decodes them:

| Bit | Meaning |
|-----|---------|
| 0 | port reset |
| 1 | device reset |
| 2 | initialise |
| 3 | interrupt write-one-to-clear mode |
| 5 | long (16-byte) command select |
| 6 | multiplier resume |
| 10 | 32-bit activation |
| 13 | multiplier enable |
| 31 | ready |

Top module: `port_ctl_reg`

## Requirements
- R1: A write with `bus_addr` = 0 sets each of the configuration bits 3, 5, 6, 10 and 13 that is written as 1. Configuration bits written as 0 keep their value.
- R2: A write with `bus_addr` = 4 clears each configuration bit that is written as 1. A write to any other address changes nothing.
- R3: After reset, `rd_data` reads 32'h0000_0001. Only port reset is set.
- R4: Port reset (bit 0) stays set until a write to address 4 has bit 0 set. The port then reads bits 0, 2 and 31 as 0. A set write of bit 0 in any state sets bit 0 at the next edge. It clears bits 2 and 31 and leaves the configuration bits unchanged.
- R5: A set write of bit 2 while port reset is clear makes bit 2 read 1 for exactly INIT_CYCLES cycles after the write edge. Bit 2 then reads 0 and bit 31 reads 1 in the same cycle. While port reset is set, a set write of bit 2 is ignored.
- R6: Bit 31 reads 0 whenever bit 0 or bit 2 reads 1. Once ready, bit 31 stays 1 until bit 0 or bit 2 is set again.
- R7: A set write of bit 1 sets device reset at the write edge. The bit stays 1 while `link_up` is 0. It clears at the first later edge at which `link_up` is 1. A set write of bit 1 wins over `link_up` at the same edge.
- R8: Clear writes to bits 1 and 2 have no effect. Bit 31 and the unassigned bits (4, 7–9, 11, 12, 14–30) ignore all writes. The unassigned bits read 0.
- R9: A set write of bit 2 during initialisation does not extend it. A set write of bit 2 while ready restarts initialisation and drops bit 31 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset: 0 = set, 4 = clear |
| bus_wdata | input | 32 | Write data: the bit mask to set or clear |
| link_up | input | 1 | Link-layer stub: 1 when the link is up |
| rd_data | output | 32 | Current status word |

## Verification
The checks assume at most one write per cycle, with the address and data held stable around the rising edge. They also assume `link_up` is a synchronous level, not a pulse narrower than a clock. The bench drives the strobe, address, data and link input only at falling edges and issues a single write per cycle, so both conditions always hold. The device-release check further assumes software does not re-set device reset in the same cycle it expects release; the bench exercises that collision on purpose, and the property excludes it.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

    localparam int WORD_W = 32;

    localparam int B_PRST  = 0;
    localparam int B_DRST  = 1;
    localparam int B_INIT  = 2;
    localparam int B_WOC   = 3;
    localparam int B_CMD16 = 5;
    localparam int B_MRES  = 6;
    localparam int B_ACT32 = 10;
    localparam int B_MEN   = 13;
    localparam int B_RDY   = 31;

    localparam logic [WORD_W-1:0] CFG_MASK =
        (WORD_W'(1) << B_WOC)   | (WORD_W'(1) << B_CMD16) |
        (WORD_W'(1) << B_MRES)  | (WORD_W'(1) << B_ACT32) |
        (WORD_W'(1) << B_MEN);

    localparam logic [WORD_W-1:0] LIVE_MASK =
        CFG_MASK | (WORD_W'(1) << B_PRST) | (WORD_W'(1) << B_DRST) |
        (WORD_W'(1) << B_INIT) | (WORD_W'(1) << B_RDY);

    typedef enum logic [1:0] {
        ST_HELD  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_INIT  = 2'd2,
        ST_READY = 2'd3
    } pctl_state_e;

endpackage

// File: rtl/pctl_wr_decode.sv
module pctl_wr_decode
    import pctl_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int SET_OFS = 0,
    parameter int CLR_OFS = 4
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] set_mask,
    output logic [WORD_W-1:0] clr_mask
);

    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFS);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

    logic hit_set;
    logic hit_clr;

    always_comb begin
        hit_set = bus_wr && (bus_addr == SET_A);
        hit_clr = bus_wr && (bus_addr == CLR_A);
    end

    always_comb begin
        set_mask = hit_set ? bus_wdata : '0;
        clr_mask = hit_clr ? bus_wdata : '0;
    end

endmodule

// File: rtl/pctl_cfg_bits.sv
module pctl_cfg_bits
    import pctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_mask,
    input  logic [WORD_W-1:0] clr_mask,
    output logic [WORD_W-1:0] cfg_q
);

    logic [WORD_W-1:0] cfg_d;

    always_comb begin
        cfg_d = (cfg_q | (set_mask & CFG_MASK)) & ~(clr_mask & CFG_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/pctl_seq.sv
module pctl_seq
    import pctl_pkg::*;
#(
    parameter int INIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_prst,
    input  logic clr_prst,
    input  logic set_init,
    input  logic set_drst,
    input  logic link_up,
    output logic prst_bit,
    output logic init_bit,
    output logic rdy_bit,
    output logic drst_bit
);

    localparam int CNT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES - 1);

    pctl_state_e state_q;
    pctl_state_e state_d;
    logic [CNT_W-1:0] cnt_q;
    logic timer_done;

    always_comb begin
        timer_done = (cnt_q == LAST);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HELD: begin
                if (clr_prst && !set_prst) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (set_prst) begin
                    state_d = ST_HELD;
                end else if (set_init) begin
                    state_d = ST_INIT;
                end
            end
            ST_INIT: begin
                if (set_prst) begin
                    state_d = ST_HELD;
                end else if (timer_done) begin
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                if (set_prst) begin
                    state_d = ST_HELD;
                end else if (set_init) begin
                    state_d = ST_INIT;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    // initialisation timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q != ST_INIT) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        prst_bit = 1'b0;
        init_bit = 1'b0;
        rdy_bit  = 1'b0;
        unique case (state_q)
            ST_HELD:  prst_bit = 1'b1;
            ST_IDLE:  ;
            ST_INIT:  init_bit = 1'b1;
            ST_READY: rdy_bit  = 1'b1;
        endcase
    end

    // device reset flag: set wins, live link releases
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drst_bit <= 1'b0;
        end else if (set_drst) begin
            drst_bit <= 1'b1;
        end else if (link_up) begin
            drst_bit <= 1'b0;
        end
    end

endmodule

// File: rtl/port_ctl_reg.sv
module port_ctl_reg
    import pctl_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int INIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              link_up,
    output logic [31:0]       rd_data
);

    logic [WORD_W-1:0] set_mask;
    logic [WORD_W-1:0] clr_mask;
    logic [WORD_W-1:0] cfg_q;
    logic prst_bit;
    logic init_bit;
    logic rdy_bit;
    logic drst_bit;

    pctl_wr_decode #(
        .ADDR_W  (ADDR_W),
        .SET_OFS (0),
        .CLR_OFS (4)
    ) i_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask)
    );

    pctl_cfg_bits i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .cfg_q    (cfg_q)
    );

    pctl_seq #(
        .INIT_CYCLES (INIT_CYCLES)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_prst (set_mask[B_PRST]),
        .clr_prst (clr_mask[B_PRST]),
        .set_init (set_mask[B_INIT]),
        .set_drst (set_mask[B_DRST]),
        .link_up  (link_up),
        .prst_bit (prst_bit),
        .init_bit (init_bit),
        .rdy_bit  (rdy_bit),
        .drst_bit (drst_bit)
    );

    always_comb begin
        rd_data         = cfg_q;
        rd_data[B_PRST] = prst_bit;
        rd_data[B_DRST] = drst_bit;
        rd_data[B_INIT] = init_bit;
        rd_data[B_RDY]  = rdy_bit;
    end

endmodule

// File: rtl/port_ctl_reg_chk.sv
module port_ctl_reg_chk
    import pctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              link_up,
    input logic [WORD_W-1:0] set_mask,
    input logic [WORD_W-1:0] clr_mask,
    input logic [WORD_W-1:0] rd_data
);

    AST_ONE_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask == '0) || (clr_mask == '0)); // R2

    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask == '0) && (clr_mask == '0)) |=> $stable(rd_data & CFG_MASK)); // R1

    AST_PRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_PRST] && !clr_mask[B_PRST]) |=> rd_data[B_PRST]); // R4

    AST_PRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_mask[B_PRST] |=> (rd_data[B_PRST] && !rd_data[B_INIT] && !rd_data[B_RDY])); // R4

    AST_INIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[B_INIT]) |-> (rd_data[B_RDY] || rd_data[B_PRST])); // R5

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_data[B_PRST], rd_data[B_INIT], rd_data[B_RDY]})); // R6

    AST_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_DRST] && !link_up) |=> rd_data[B_DRST]); // R7

    AST_DEV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_DRST] && link_up && !set_mask[B_DRST]) |=> !rd_data[B_DRST]); // R7

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~LIVE_MASK) == '0); // R8

endmodule

bind port_ctl_reg port_ctl_reg_chk i_port_ctl_reg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_up  (link_up),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .rd_data  (rd_data)
);

// File: tb/test_port_ctl_reg.sv
module test_port_ctl_reg;

    localparam int AW = 3;
    localparam int IC = 5;
    localparam logic [31:0] CFGM = 32'h0000_2468; // bits 3,5,6,10,13
    localparam logic [31:0] RDY  = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        link_up = 1'b0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_cfg;

    always #2 clk = ~clk;

    port_ctl_reg #(.ADDR_W(AW), .INIT_CYCLES(IC)) i_port_ctl_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .link_up   (link_up),
        .rd_data   (rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic run_init(input string req, input logic [31:0] base);
        wr(3'd0, 32'h4);
        for (int i = 0; i < IC; i++) begin
            chk(req, rd_data, base | 32'h4);
            step();
        end
        chk(req, rd_data, base | RDY);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_cfg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset value", rd_data, 32'h1);

        // R5: init ignored while held
        wr(3'd0, 32'h4);
        chk("R5 init ignored in reset", rd_data, 32'h1);
        repeat (IC + 1) step();
        chk("R5 init still ignored", rd_data, 32'h1);

        // R1/R2 while held
        wr(3'd0, 32'h8);
        chk("R1 set woc bit", rd_data, 32'h9);
        wr(3'd4, 32'h8);
        chk("R2 clear woc bit", rd_data, 32'h1);

        // R8: clear of action bits 1,2 ignored
        wr(3'd4, 32'h6);
        chk("R8 clear of bits 1,2 ignored", rd_data, 32'h1);

        // R4: release port reset
        wr(3'd4, 32'h1);
        chk("R4 released to idle", rd_data, 32'h0);
        repeat (IC + 2) step();
        chk("R6 idle is not ready", rd_data, 32'h0);

        // R5/R6 initialisation
        run_init("R5 init window", 32'h0);
        repeat (4) step();
        chk("R6 ready holds", rd_data, RDY);

        // R9: restart from ready, re-set mid-init does not extend
        wr(3'd0, 32'h4);
        chk("R9 restart drops ready", rd_data, 32'h4);
        step();
        wr(3'd0, 32'h4);
        for (int i = 2; i < IC; i++) begin
            chk("R9 init window", rd_data, 32'h4);
            step();
        end
        chk("R9 not extended", rd_data, RDY);

        // R1/R8 sweep: set each bit 3..31 one at a time
        for (int b = 3; b < 32; b++) begin
            wr(3'd0, 32'h1 << b);
            exp_cfg = exp_cfg | ((32'h1 << b) & CFGM);
            chk("R1 set sweep", rd_data, RDY | exp_cfg);
        end
        // zero writes have no effect
        wr(3'd0, 32'h0);
        chk("R1 zero set write", rd_data, RDY | exp_cfg);
        wr(3'd4, 32'h0);
        chk("R2 zero clear write", rd_data, RDY | exp_cfg);
        // R2: other addresses ignored
        for (int a = 0; a < 8; a++) begin
            if (a != 0 && a != 4) begin
                wr(AW'(a), 32'hFFFF_FFFF);
                chk("R2 foreign address", rd_data, RDY | exp_cfg);
            end
        end
        // R2/R8 sweep: clear each bit 3..31 one at a time
        for (int b = 3; b < 32; b++) begin
            wr(3'd4, 32'h1 << b);
            exp_cfg = exp_cfg & ~(32'h1 << b);
            chk("R2 clear sweep", rd_data, RDY | exp_cfg);
        end
        wr(3'd0, 32'hFFFF_FFF8);
        exp_cfg = CFGM;
        chk("R8 bulk set", rd_data, RDY | exp_cfg);
        wr(3'd4, 32'h0000_0408);
        exp_cfg = CFGM & ~32'h0000_0408;
        chk("R2 bulk clear", rd_data, RDY | exp_cfg);

        // R7: device reset
        wr(3'd0, 32'h2);
        chk("R7 device reset set", rd_data, RDY | exp_cfg | 32'h2);
        for (int i = 0; i < 12; i++) begin
            step();
            chk("R7 held without link", rd_data, RDY | exp_cfg | 32'h2);
        end
        link_up = 1'b1;
        step();
        chk("R7 released by link", rd_data, RDY | exp_cfg);
        wr(3'd0, 32'h2);
        chk("R7 set wins over link", rd_data, RDY | exp_cfg | 32'h2);
        step();
        chk("R7 release next edge", rd_data, RDY | exp_cfg);
        link_up = 1'b0;

        // R4: port reset from ready keeps config
        wr(3'd0, 32'h1);
        chk("R4 reset from ready", rd_data, 32'h1 | exp_cfg);
        wr(3'd4, 32'h1);
        chk("R4 release again", rd_data, exp_cfg);
        // R4: port reset during init
        wr(3'd0, 32'h4);
        step();
        wr(3'd0, 32'h1);
        chk("R4 reset aborts init", rd_data, 32'h1 | exp_cfg);
        repeat (IC + 1) step();
        chk("R4 stays held", rd_data, 32'h1 | exp_cfg);
        wr(3'd4, 32'h1);
        run_init("R5 init after abort", exp_cfg);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule